// File: doc/BRIEF.md
# File Register Read-Modify-Write Unit

This unit carries out one byte-wide or single-bit operation on a local bank of 128 eight-bit registers, working together with an accumulator register. A request names an operation, a register address, a destination bit and a bit index. The unit always fetches the addressed register first. It then computes the result and commits it either to the accumulator or back to the same register. The carry, half-carry and zero status flags are updated according to the operation.

Each request passes through three clocked phases: read, modify and write. A one-cycle completion pulse follows the write. The accumulator, the flags and the operand that was last fetched can all be seen at the ports. The register bank itself is observed by moving a register into the accumulator.

Top module: `rmw_file_unit`

## Requirements
- R1: After reset the accumulator, carry, half-carry and zero are 0, every register in the bank holds 0x00, `lastRead` is 0x00, and `busy` and `done` are low.
- R2: A `start` sampled high while the unit is idle launches an operation. `busy` is high from the next cycle. The fourth rising edge, counting the one that sampled `start`, commits the result. `done` is high for exactly the one cycle after that edge, and in that cycle `busy` is low.
- R3: Every operation, including ones that only write the register, fetches the addressed register first and shows that value on `lastRead`.
- R4: With `destSel`=0 the result goes to the accumulator and the register keeps its value. With `destSel`=1 the result goes to the register and the accumulator keeps its value. Move-accumulator-to-register (code 12) always writes the register, whatever `destSel` is.
- R5: Add (code 1) forms register + accumulator. Carry is the carry out of bit 7, half-carry is the carry out of bit 3, and zero is set when the 8-bit result is 0x00.
- R6: Subtract (code 2) forms register − accumulator. Carry is 1 when no borrow occurs (register ≥ accumulator). Half-carry is 1 when the low nibble of the register is ≥ the low nibble of the accumulator. Zero is set when the result is 0x00.
- R7: The following operations set zero from the 8-bit result and leave carry and half-carry unchanged: move register (code 0), AND (3), OR (4), XOR (5), complement (6), increment (7), decrement (8) and clear (9).
- R8: Bit clear (code 10) and bit set (code 11) change only the bit chosen by the 3-bit `bitSel` of the addressed register. They always write the register and leave all three flags unchanged.
- R9: A `start` that arrives while `busy` is high is ignored. It launches no second operation and changes no register.
- R10: Codes 13 to 15 perform the fetch but write neither the accumulator nor the register, and they leave the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| start | input | 1 | Launch request, sampled when idle |
| opSel | input | 4 | Operation code |
| fileAddr | input | 7 | Register bank address |
| destSel | input | 1 | 0: accumulator, 1: register |
| bitSel | input | 3 | Bit index for bit operations |
| wOut | output | 8 | Accumulator value |
| carryOut | output | 1 | Carry flag |
| digitCarryOut | output | 1 | Half-carry flag |
| zeroOut | output | 1 | Zero flag |
| lastRead | output | 8 | Operand fetched by the latest read phase |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions take for granted that reset is applied before the first request. They also assume that the request fields stay meaningful only on the cycle `start` is sampled, since the unit captures them there and ignores them afterwards. The stimulus drives fields and `start` on the falling edge, lowers `start` after one cycle, and waits for `done` before it issues the next request. The single exception is the overlap test, which holds `start` high into the busy window on purpose. Because the bank can only be loaded through its own operations, the vector sequence builds its operands with bit sets, increments and decrements, and it checks each stored value later through `lastRead`.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
  localparam int DataW = 8;
  localparam int AddrW = 7;
  localparam int Depth = 1 << AddrW;
  localparam int BitW  = $clog2(DataW);
  localparam int OpW   = 4;
  localparam int NibW  = DataW / 2;

  typedef enum logic [OpW-1:0] {
    OP_MOVF  = 4'd0,
    OP_ADD   = 4'd1,
    OP_SUB   = 4'd2,
    OP_AND   = 4'd3,
    OP_IOR   = 4'd4,
    OP_XOR   = 4'd5,
    OP_COM   = 4'd6,
    OP_INC   = 4'd7,
    OP_DEC   = 4'd8,
    OP_CLR   = 4'd9,
    OP_BCLR  = 4'd10,
    OP_BSET  = 4'd11,
    OP_MOVWF = 4'd12,
    OP_RSV13 = 4'd13,
    OP_RSV14 = 4'd14,
    OP_RSV15 = 4'd15
  } opKind_t;

  typedef struct packed {
    logic capture;
    logic readEn;
    logic modifyEn;
    logic writeEn;
  } phaseStrobe_t;
endpackage

// File: rtl/rmw_ctrl.sv
module rmw_ctrl
  import rmw_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  output phaseStrobe_t strobe,
  output logic         busy,
  output logic         done
);
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_MODIFY, ST_WRITE} phase_t;
  phase_t state;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      done <= (state == ST_WRITE);
      unique case (state)
        ST_IDLE:   if (start) state <= ST_READ;
        ST_READ:   state <= ST_MODIFY;
        ST_MODIFY: state <= ST_WRITE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.capture  = (state == ST_IDLE) && start;
    strobe.readEn   = (state == ST_READ);
    strobe.modifyEn = (state == ST_MODIFY);
    strobe.writeEn  = (state == ST_WRITE);
  end

  assign busy = (state != ST_IDLE);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R2
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R2
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (busy && !strobe.writeEn) |=> busy); // R9
endmodule

// File: rtl/rmw_datapath.sv
module rmw_datapath
  import rmw_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  phaseStrobe_t       strobe,
  input  logic [OpW-1:0]     opSel,
  input  logic [AddrW-1:0]   fileAddr,
  input  logic               destSel,
  input  logic [BitW-1:0]    bitSel,
  output logic [DataW-1:0]   wReg,
  output logic               cFlag,
  output logic               dcFlag,
  output logic               zFlag,
  output logic [DataW-1:0]   operand
);
  logic [DataW-1:0] bank [Depth];
  opKind_t          opR;
  logic [AddrW-1:0] addrR;
  logic             destR;
  logic [BitW-1:0]  bitR;

  logic [DataW-1:0] aluRes, resR;
  logic             aluC, aluDc, cR, dcR;
  logic [DataW:0]   sum9, diff9;
  logic [NibW:0]    sumNib;
  logic [DataW-1:0] bitMask;
  logic             isBitOp, updArith, updZero, toFile, toW;

  always_comb begin
    sum9    = {1'b0, operand} + {1'b0, wReg};
    diff9   = {1'b0, operand} - {1'b0, wReg};
    sumNib  = {1'b0, operand[NibW-1:0]} + {1'b0, wReg[NibW-1:0]};
    bitMask = DataW'(1) << bitR;
    aluC    = cFlag;
    aluDc   = dcFlag;
    unique case (opR)
      OP_MOVF:  aluRes = operand;
      OP_ADD: begin
        aluRes = sum9[DataW-1:0];
        aluC   = sum9[DataW];
        aluDc  = sumNib[NibW];
      end
      OP_SUB: begin
        aluRes = diff9[DataW-1:0];
        aluC   = ~diff9[DataW];
        aluDc  = (operand[NibW-1:0] >= wReg[NibW-1:0]);
      end
      OP_AND:   aluRes = operand & wReg;
      OP_IOR:   aluRes = operand | wReg;
      OP_XOR:   aluRes = operand ^ wReg;
      OP_COM:   aluRes = ~operand;
      OP_INC:   aluRes = operand + DataW'(1);
      OP_DEC:   aluRes = operand - DataW'(1);
      OP_CLR:   aluRes = '0;
      OP_BCLR:  aluRes = operand & ~bitMask;
      OP_BSET:  aluRes = operand | bitMask;
      OP_MOVWF: aluRes = wReg;
      default:  aluRes = operand;
    endcase
  end

  always_comb begin
    isBitOp  = (opR == OP_BCLR) || (opR == OP_BSET);
    updArith = (opR == OP_ADD) || (opR == OP_SUB);
    updZero  = (opR <= OP_CLR);
    toFile   = isBitOp || (opR == OP_MOVWF) || (destR && (opR <= OP_CLR));
    toW      = !destR && (opR <= OP_CLR);
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      opR     <= OP_MOVF;
      addrR   <= '0;
      destR   <= 1'b1;
      bitR    <= '0;
      operand <= '0;
      resR    <= '0;
      cR      <= 1'b0;
      dcR     <= 1'b0;
      wReg    <= '0;
      cFlag   <= 1'b0;
      dcFlag  <= 1'b0;
      zFlag   <= 1'b0;
      for (int i = 0; i < Depth; i++) bank[i] <= '0;
    end else begin
      if (strobe.capture) begin
        opR   <= opKind_t'(opSel);
        addrR <= fileAddr;
        destR <= destSel;
        bitR  <= bitSel;
      end
      if (strobe.readEn) operand <= bank[addrR];
      if (strobe.modifyEn) begin
        resR <= aluRes;
        cR   <= aluC;
        dcR  <= aluDc;
      end
      if (strobe.writeEn) begin
        if (toFile) bank[addrR] <= resR;
        if (toW) wReg <= resR;
        if (updArith) begin
          cFlag  <= cR;
          dcFlag <= dcR;
        end
        if (updZero) zFlag <= (resR == '0);
      end
    end
  end

  AST_READ_BEFORE_WRITE: assert property (@(posedge clk) disable iff (rst)
    strobe.writeEn |-> $past(strobe.readEn, 2)); // R3
  AST_W_KEPT_ON_FILE_DEST: assert property (@(posedge clk) disable iff (rst)
    $past(strobe.writeEn && !toW) |-> wReg == $past(wReg)); // R4
  AST_BITOP_FLAGS_KEPT: assert property (@(posedge clk) disable iff (rst)
    $past(strobe.writeEn && isBitOp) |-> {cFlag, dcFlag, zFlag} == $past({cFlag, dcFlag, zFlag})); // R8
  AST_ZERO_TRACKS_W: assert property (@(posedge clk) disable iff (rst)
    $past(strobe.writeEn && updZero && toW) |-> zFlag == (wReg == '0)); // R7
endmodule

// File: rtl/rmw_file_unit.sv
module rmw_file_unit
  import rmw_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [OpW-1:0]   opSel,
  input  logic [AddrW-1:0] fileAddr,
  input  logic             destSel,
  input  logic [BitW-1:0]  bitSel,
  output logic [DataW-1:0] wOut,
  output logic             carryOut,
  output logic             digitCarryOut,
  output logic             zeroOut,
  output logic [DataW-1:0] lastRead,
  output logic             busy,
  output logic             done
);
  phaseStrobe_t strobe;

  rmw_ctrl uCtrl (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .strobe (strobe),
    .busy   (busy),
    .done   (done)
  );

  rmw_datapath uPath (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .opSel    (opSel),
    .fileAddr (fileAddr),
    .destSel  (destSel),
    .bitSel   (bitSel),
    .wReg     (wOut),
    .cFlag    (carryOut),
    .dcFlag   (digitCarryOut),
    .zFlag    (zeroOut),
    .operand  (lastRead)
  );
endmodule

// File: tb/rmw_file_unit_test.sv
module rmw_file_unit_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [3:0] opSel = '0;
  logic [6:0] fileAddr = '0;
  logic       destSel = 1'b1;
  logic [2:0] bitSel = '0;
  logic [7:0] wOut, lastRead;
  logic       carryOut, digitCarryOut, zeroOut, busy, done;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  rmw_file_unit uut (
    .clk(clk), .rst(rst), .start(start), .opSel(opSel), .fileAddr(fileAddr),
    .destSel(destSel), .bitSel(bitSel), .wOut(wOut), .carryOut(carryOut),
    .digitCarryOut(digitCarryOut), .zeroOut(zeroOut), .lastRead(lastRead),
    .busy(busy), .done(done)
  );

  // {op[4], addr[7], dest, bit[3], expRead[8], expW[8], expFlags{C,DC,Z}[3]}
  localparam int NumVec = 31;
  localparam logic [33:0] vecs [NumVec] = '{
    {4'd11, 7'd5,   1'b1, 3'd3, 8'h00, 8'h00, 3'b000},
    {4'd11, 7'd5,   1'b1, 3'd1, 8'h08, 8'h00, 3'b000},
    {4'd11, 7'd5,   1'b1, 3'd7, 8'h0A, 8'h00, 3'b000},
    {4'd0,  7'd5,   1'b0, 3'd0, 8'h8A, 8'h8A, 3'b000},
    {4'd1,  7'd5,   1'b1, 3'd0, 8'h8A, 8'h8A, 3'b110},
    {4'd0,  7'd5,   1'b0, 3'd0, 8'h14, 8'h14, 3'b110},
    {4'd8,  7'd6,   1'b1, 3'd0, 8'h00, 8'h14, 3'b110},
    {4'd1,  7'd6,   1'b0, 3'd0, 8'hFF, 8'h13, 3'b110},
    {4'd2,  7'd6,   1'b1, 3'd0, 8'hFF, 8'h13, 3'b110},
    {4'd2,  7'd7,   1'b0, 3'd0, 8'h00, 8'hED, 3'b000},
    {4'd5,  7'd6,   1'b0, 3'd0, 8'hEC, 8'h01, 3'b000},
    {4'd3,  7'd5,   1'b0, 3'd0, 8'h14, 8'h00, 3'b001},
    {4'd4,  7'd6,   1'b1, 3'd0, 8'hEC, 8'h00, 3'b000},
    {4'd6,  7'd6,   1'b0, 3'd0, 8'hEC, 8'h13, 3'b000},
    {4'd12, 7'd8,   1'b0, 3'd0, 8'h00, 8'h13, 3'b000},
    {4'd7,  7'd8,   1'b1, 3'd0, 8'h13, 8'h13, 3'b000},
    {4'd2,  7'd8,   1'b0, 3'd0, 8'h14, 8'h01, 3'b110},
    {4'd2,  7'd8,   1'b1, 3'd0, 8'h14, 8'h01, 3'b110},
    {4'd10, 7'd8,   1'b1, 3'd4, 8'h13, 8'h01, 3'b110},
    {4'd0,  7'd8,   1'b0, 3'd0, 8'h03, 8'h03, 3'b110},
    {4'd2,  7'd8,   1'b1, 3'd0, 8'h03, 8'h03, 3'b111},
    {4'd9,  7'd5,   1'b1, 3'd0, 8'h14, 8'h03, 3'b111},
    {4'd8,  7'd5,   1'b0, 3'd0, 8'h00, 8'hFF, 3'b110},
    {4'd8,  7'd5,   1'b1, 3'd0, 8'h00, 8'hFF, 3'b110},
    {4'd7,  7'd5,   1'b1, 3'd0, 8'hFF, 8'hFF, 3'b111},
    {4'd1,  7'd5,   1'b0, 3'd0, 8'h00, 8'hFF, 3'b000},
    {4'd1,  7'd6,   1'b0, 3'd0, 8'hEC, 8'hEB, 3'b110},
    {4'd13, 7'd6,   1'b1, 3'd0, 8'hEC, 8'hEB, 3'b110},
    {4'd0,  7'd6,   1'b0, 3'd0, 8'hEC, 8'hEC, 3'b110},
    {4'd11, 7'd127, 1'b1, 3'd0, 8'h00, 8'hEC, 3'b110},
    {4'd0,  7'd127, 1'b0, 3'd0, 8'h01, 8'h01, 3'b110}
  };

  function automatic string reqOf(input logic [3:0] op);
    case (op)
      4'd1:          return "R5";
      4'd2:          return "R6";
      4'd10, 4'd11:  return "R8";
      4'd12:         return "R4";
      4'd13, 4'd14, 4'd15: return "R10";
      default:       return "R7";
    endcase
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic doOp(input logic [3:0] op, input logic [6:0] addr, input logic d, input logic [2:0] b);
    @(negedge clk);
    opSel = op; fileAddr = addr; destSel = d; bitSel = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 10; k++) begin
      if (done) break;
      @(negedge clk);
    end
    check("R2", "done seen", int'(done), 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1", "W", int'(wOut), 0);
    check("R1", "flags", int'({carryOut, digitCarryOut, zeroOut}), 0);
    check("R1", "lastRead", int'(lastRead), 0);
    check("R1", "busy", int'(busy), 0);
    check("R1", "done", int'(done), 0);

    for (int i = 0; i < NumVec; i++) begin
      logic [33:0] v;
      v = vecs[i];
      doOp(v[33:30], v[29:23], v[22], v[21:19]);
      check("R3", "lastRead", int'(lastRead), int'(v[18:11]));
      check(reqOf(v[33:30]), "W", int'(wOut), int'(v[10:3]));
      check(reqOf(v[33:30]), "flags", int'({carryOut, digitCarryOut, zeroOut}), int'(v[2:0]));
    end

    // R2 cycle timing: increment f12 into W
    @(negedge clk);
    opSel = 4'd7; fileAddr = 7'd12; destSel = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2", "busy after start", int'(busy), 1);
    check("R2", "done early 1", int'(done), 0);
    @(negedge clk);
    check("R2", "done early 2", int'(done), 0);
    @(negedge clk);
    check("R2", "done early 3", int'(done), 0);
    @(negedge clk);
    check("R2", "done on time", int'(done), 1);
    check("R2", "busy with done", int'(busy), 0);
    check("R2", "W after inc", int'(wOut), 8'h01);
    @(negedge clk);
    check("R2", "done one cycle", int'(done), 0);

    // R9 start held into busy window with a different request
    @(negedge clk);
    opSel = 4'd8; fileAddr = 7'd10; destSel = 1'b1; start = 1'b1;
    @(negedge clk);
    opSel = 4'd11; fileAddr = 7'd11; bitSel = 3'd2;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    check("R9", "done once", int'(done), 0);
    check("R9", "idle", int'(busy), 0);
    doOp(4'd0, 7'd11, 1'b0, 3'd0);
    check("R9", "f11 untouched", int'(wOut), 0);
    doOp(4'd0, 7'd10, 1'b0, 3'd0);
    check("R9", "f10 decremented", int'(wOut), 8'hFF);

    // R1 reset mid-stream clears W, flags and the bank
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "W after reset", int'(wOut), 0);
    check("R1", "flags after reset", int'({carryOut, digitCarryOut, zeroOut}), 0);
    doOp(4'd0, 7'd6, 1'b0, 3'd0);
    check("R1", "bank cleared", int'(lastRead), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule